// File: doc/BRIEF.md
# Bidirectional Saturating Barrel Shifter

This block shifts or rotates a 64-bit operand by a signed amount in a single pass. Each mode has a natural direction. A negative amount turns that direction around. A reversed shift of magnitude m is carried out as a shift by m-1 followed by one more single-bit step. Because of this split, a magnitude equal to the full container width gives a defined result.

Two saturating modes clamp a left shift of a 32-bit operand to the signed 32-bit range. They choose the bound from the sign of the original operand. The `sat_o` strobe marks every result where a bound replaced the shifted value, so a datapath can feed it into a sticky overflow flag.

A width select picks 64-bit operation or 32-bit operation. In 32-bit operation the low word is extended into the 64-bit container, shifted there, and returned zero-extended. A parameter selects whether the result and strobe are registered.

Top module: `bidir_sat_shifter`

## Requirements
- R1: `mode_i` codes are 0 arithmetic right, 1 logical right, 2 arithmetic left, 3 logical left, 4 saturating left, 5 saturating right, 6 rotate left and 7 rotate right. A non-negative amount shifts in the mode's own direction, so an amount of 0 returns the (width-adjusted) operand with `sat_o` low.
- R2: A negative amount -m shifts the opposite way by m, performed as m-1 then 1. Reversed right shifts fill with the sign bit in arithmetic modes (0, 2, 4, 5) and with zeros in logical modes (1, 3). Left shifts always fill with zeros.
- R3: With `wide_i`=0, the low 32 bits of `src_i` are sign-extended (arithmetic modes) or zero-extended (logical modes) into a 64-bit container. The container is shifted and only the low 32 bits are returned, with `res_o[63:32]` = 0.
- R4: A total shift of 64 positions or more gives 0 for left and logical right shifts and a full sign fill for arithmetic right shifts. This applies in both widths, because the container is always 64 bits.
- R5: Modes 4 and 5 always work on `src_i[31:0]`, ignore `wide_i` and return a zero-extended 32-bit result. Suppose the shifted value, clamped to signed 32 bits, has a sign different from the original operand. Then the result is the bound of the original sign: 0x7FFFFFFF if non-negative, 0x80000000 if negative.
- R6: In a saturating left shift, a strictly positive original whose shifted value is exactly zero gives 0x7FFFFFFF.
- R7: In every other saturating left-shift case the result is the shifted value clamped to signed 32 bits. Mode 4 with a negative amount is a plain arithmetic right shift with no clamping.
- R8: Mode 5 applies the saturating left-shift rule only for a negative amount. A non-negative amount gives a plain arithmetic right shift.
- R9: Rotates take the amount modulo the active width (32 or 64) in two's complement, so -k rotates by k the other way. An amount that is 0 modulo the width returns the operand unchanged.
- R10: `sat_o` is high exactly when a bound value replaced the shifted value, and it accompanies that result.
- R11: With `REG_OUT`=1 the result and strobe appear one clock after the inputs, and a synchronous active-low reset clears both to 0. With `REG_OUT`=0 the block is purely combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | DATA_W | Operand |
| amt_i | input | AMT_W | Signed shift or rotate amount |
| mode_i | input | 3 | Operation code (R1) |
| wide_i | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| res_o | output | DATA_W | Result |
| sat_o | output | 1 | Saturation occurred for this result |

## Verification
The assertions take for granted that every input is a known value when the clock rises. With the output register they compare results against copies of the inputs captured one clock earlier, so they also assume those inputs were sampled on the same edge as the design. The stimulus changes all inputs only at the falling clock edge and never leaves an input unknown. It uses only the eight defined mode codes and amounts over the whole signed range from -64 to 63.

// File: rtl/bss_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the bidirectional saturating shifter.
// Assumes a 3-bit operation code; all eight codes are defined.
package bss_pkg;

    typedef enum logic [2:0] {
        SH_ASR  = 3'd0,
        SH_LSR  = 3'd1,
        SH_ASL  = 3'd2,
        SH_LSL  = 3'd3,
        SH_SATL = 3'd4,
        SH_SATR = 3'd5,
        SH_ROL  = 3'd6,
        SH_ROR  = 3'd7
    } sh_mode_e;

    // True for modes that keep the operand sign (arithmetic fill / sign extension)
    function automatic logic mode_is_arith(input sh_mode_e m);
        return !(m == SH_LSR || m == SH_LSL);
    endfunction

    // True for modes whose positive amount shifts toward the MSB
    function automatic logic mode_is_left(input sh_mode_e m);
        return (m == SH_ASL || m == SH_LSL || m == SH_SATL);
    endfunction

    // True for the two clamping modes
    function automatic logic mode_is_sat(input sh_mode_e m);
        return (m == SH_SATL || m == SH_SATR);
    endfunction

    // True for the two rotate modes
    function automatic logic mode_is_rot(input sh_mode_e m);
        return (m == SH_ROL || m == SH_ROR);
    endfunction

endpackage

// File: rtl/bss_barrel.sv
`timescale 1ns/1ps
// Logarithmic shifter: shifts by step_i plus one extra position when
// extra_i is set, toward the MSB when left_i is set, otherwise toward the
// LSB with fill_i entering at the top. Left shifts are done by reversing
// the word around a right shifter, so the fill is forced to zero for them.
// Assumes W > 2**(SH_W-1).
module bss_barrel #(
    parameter int W    = 64,
    parameter int SH_W = 6
) (
    input  logic [W-1:0]    data_i,
    input  logic [SH_W-1:0] step_i,
    input  logic            extra_i,
    input  logic            left_i,
    input  logic            fill_i,
    output logic [W-1:0]    data_o
);

    logic [W-1:0] stg [0:SH_W];
    logic [W-1:0] tail;
    logic         fbit;

    // Mirror a word end for end
    function automatic logic [W-1:0] flip(input logic [W-1:0] d);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            r[i] = d[W-1-i];
        end
        return r;
    endfunction

    assign fbit   = fill_i & ~left_i;
    assign stg[0] = left_i ? flip(data_i) : data_i;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int DIST = 1 << k;
        assign stg[k+1] = step_i[k] ? {{DIST{fbit}}, stg[k][W-1:DIST]} : stg[k];
    end

    // Trailing single-position step used by reversed shifts
    always_comb begin
        tail = extra_i ? {fbit, stg[SH_W][W-1:1]} : stg[SH_W];
    end

    assign data_o = left_i ? flip(tail) : tail;

endmodule

// File: rtl/bss_rotator.sv
`timescale 1ns/1ps
// Logarithmic right rotator. A narrower rotate is obtained by the caller
// duplicating the low half into both halves and keeping the amount below
// the half width. Assumes W == 2**SH_W.
module bss_rotator #(
    parameter int W    = 64,
    parameter int SH_W = 6
) (
    input  logic [W-1:0]    data_i,
    input  logic [SH_W-1:0] amt_i,
    output logic [W-1:0]    data_o
);

    logic [W-1:0] stg [0:SH_W];

    assign stg[0] = data_i;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int DIST = 1 << k;
        assign stg[k+1] = amt_i[k] ? {stg[k][DIST-1:0], stg[k][W-1:DIST]} : stg[k];
    end

    assign data_o = stg[SH_W];

endmodule

// File: rtl/bss_sat.sv
`timescale 1ns/1ps
// Clamp for saturating left shifts. Takes the shifted container value and
// the original narrow operand and yields the narrow result plus a flag
// that a bound was substituted. The bound is picked from the original sign
// when the clamped value disagrees with it, or when a positive operand was
// shifted down to zero. Assumes W > NW.
module bss_sat #(
    parameter int W  = 64,
    parameter int NW = 32
) (
    input  logic [W-1:0]  val_i,
    input  logic [NW-1:0] orig_i,
    output logic [NW-1:0] res_o,
    output logic          hit_o
);

    localparam logic [NW-1:0] POS_LIM = {1'b0, {(NW-1){1'b1}}};
    localparam logic [NW-1:0] NEG_LIM = {1'b1, {(NW-1){1'b0}}};

    logic          fits;
    logic [NW-1:0] clamped;

    // Value fits when all bits from the narrow sign upward agree
    always_comb begin
        fits    = (&val_i[W-1:NW-1]) | ~(|val_i[W-1:NW-1]);
        clamped = fits ? val_i[NW-1:0] : (val_i[W-1] ? NEG_LIM : POS_LIM);
    end

    // Choose between the clamped value and the original-sign bound
    always_comb begin
        if (clamped[NW-1] != orig_i[NW-1]) begin
            res_o = orig_i[NW-1] ? NEG_LIM : POS_LIM;
            hit_o = 1'b1;
        end else if (!orig_i[NW-1] && (|orig_i) && !(|val_i)) begin
            res_o = POS_LIM;
            hit_o = 1'b1;
        end else begin
            res_o = clamped;
            hit_o = ~fits;
        end
    end

endmodule

// File: rtl/bidir_sat_shifter.sv
`timescale 1ns/1ps
// Bidirectional saturating barrel shifter. Decodes the signed amount into
// a direction, a step count and a trailing single step, then drives a
// shared shifter, a rotator and a 32-bit clamp, and selects among them by
// mode. Narrow operation reuses the full-width container. Assumes inputs
// are known each cycle; with REG_OUT set, outputs lag inputs by one clock.
module bidir_sat_shifter #(
    parameter int DATA_W  = 64,
    parameter bit REG_OUT = 1'b1,
    localparam int SH_W   = $clog2(DATA_W),
    localparam int AMT_W  = SH_W + 1,
    localparam int NW     = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [2:0]        mode_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] res_o,
    output logic              sat_o
);
    import bss_pkg::*;

    sh_mode_e          mode;
    logic              narrow;
    logic              arith;
    logic              neg;
    logic              go_left;
    logic [SH_W-1:0]   step;
    logic [DATA_W-1:0] prep;
    logic [DATA_W-1:0] rot_src;
    logic [SH_W-1:0]   rot_amt;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] rotated;
    logic [NW-1:0]     sat_res;
    logic              sat_hit;
    logic              use_sat;
    logic [DATA_W-1:0] res_c;
    logic              sat_c;

    // Mode attributes and operand width handling
    always_comb begin
        mode    = sh_mode_e'(mode_i);
        narrow  = ~wide_i | mode_is_sat(mode);
        arith   = mode_is_arith(mode);
        prep    = narrow ? {{NW{arith & src_i[NW-1]}}, src_i[NW-1:0]} : src_i;
        rot_src = narrow ? {src_i[NW-1:0], src_i[NW-1:0]} : src_i;
    end

    // Amount decode: negative -m becomes a step of m-1, which is ~amt
    always_comb begin
        neg     = amt_i[AMT_W-1];
        step    = neg ? ~amt_i[SH_W-1:0] : amt_i[SH_W-1:0];
        go_left = mode_is_left(mode) ^ neg;
        use_sat = (mode == SH_SATL && !neg) || (mode == SH_SATR && neg);
    end

    // Rotate amount as a right rotate, reduced modulo the active width
    always_comb begin
        rot_amt = (mode == SH_ROL) ? (~amt_i[SH_W-1:0] + 1'b1) : amt_i[SH_W-1:0];
        if (narrow) begin
            rot_amt[SH_W-1] = 1'b0;
        end
    end

    bss_barrel #(
        .W    (DATA_W),
        .SH_W (SH_W)
    ) shift_i (
        .data_i  (prep),
        .step_i  (step),
        .extra_i (neg),
        .left_i  (go_left),
        .fill_i  (arith & prep[DATA_W-1]),
        .data_o  (shifted)
    );

    bss_rotator #(
        .W    (DATA_W),
        .SH_W (SH_W)
    ) rot_i (
        .data_i (rot_src),
        .amt_i  (rot_amt),
        .data_o (rotated)
    );

    bss_sat #(
        .W  (DATA_W),
        .NW (NW)
    ) sat_i (
        .val_i  (shifted),
        .orig_i (src_i[NW-1:0]),
        .res_o  (sat_res),
        .hit_o  (sat_hit)
    );

    // Result selection and narrow-mode upper-half clearing
    always_comb begin
        sat_c = 1'b0;
        if (mode_is_rot(mode)) begin
            res_c = rotated;
        end else if (use_sat) begin
            res_c = {{NW{1'b0}}, sat_res};
            sat_c = sat_hit;
        end else begin
            res_c = shifted;
        end
        if (narrow) begin
            res_c[DATA_W-1:NW] = '0;
        end
    end

    if (REG_OUT) begin : g_reg
        // Output register with synchronous active-low clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_o <= '0;
                sat_o <= 1'b0;
            end else begin
                res_o <= res_c;
                sat_o <= sat_c;
            end
        end
    end else begin : g_comb
        assign res_o = res_c;
        assign sat_o = sat_c;
    end

endmodule

// File: rtl/bidir_sat_shifter_chk.sv
`timescale 1ns/1ps
// Property checker for the shifter. Keeps copies of the inputs aligned
// with the outputs (one clock late when the output is registered) and
// checks port-level relations. Assumes inputs are known at each edge.
module bidir_sat_shifter_chk #(
    parameter int DATA_W  = 64,
    parameter bit REG_OUT = 1'b1,
    localparam int SH_W   = $clog2(DATA_W),
    localparam int AMT_W  = SH_W + 1,
    localparam int NW     = DATA_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] src_i,
    input logic [AMT_W-1:0]  amt_i,
    input logic [2:0]        mode_i,
    input logic              wide_i,
    input logic [DATA_W-1:0] res_o,
    input logic              sat_o
);
    import bss_pkg::*;

    localparam logic [NW-1:0] POS_LIM = {1'b0, {(NW-1){1'b1}}};
    localparam logic [NW-1:0] NEG_LIM = {1'b1, {(NW-1){1'b0}}};

    logic [DATA_W-1:0] q_src;
    logic [AMT_W-1:0]  q_amt;
    logic [2:0]        q_mode;
    logic              q_wide;
    logic              q_narrow;
    logic              q_rot_zero;
    logic [DATA_W-1:0] q_plain;

    if (REG_OUT) begin : g_delay
        // Capture inputs so they line up with the registered outputs
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_src  <= '0;
                q_amt  <= '0;
                q_mode <= '0;
                q_wide <= 1'b0;
            end else begin
                q_src  <= src_i;
                q_amt  <= amt_i;
                q_mode <= mode_i;
                q_wide <= wide_i;
            end
        end
    end else begin : g_direct
        assign q_src  = src_i;
        assign q_amt  = amt_i;
        assign q_mode = mode_i;
        assign q_wide = wide_i;
    end

    // Derived views of the aligned inputs
    always_comb begin
        q_narrow   = !q_wide || q_mode == SH_SATL || q_mode == SH_SATR;
        q_rot_zero = q_narrow ? (q_amt[SH_W-2:0] == '0) : (q_amt[SH_W-1:0] == '0);
        q_plain    = q_narrow ? {{NW{1'b0}}, q_src[NW-1:0]} : q_src;
    end

    // R10
    sat_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> (q_mode == SH_SATL || q_mode == SH_SATR));

    // R5
    sat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> (res_o[DATA_W-1:NW] == '0 &&
                   (res_o[NW-1:0] == POS_LIM || res_o[NW-1:0] == NEG_LIM)));

    // R5
    sat_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> (res_o[NW-1] == q_src[NW-1]));

    // R3
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_narrow |-> (res_o[DATA_W-1:NW] == '0));

    // R9
    rot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_mode == SH_ROL || q_mode == SH_ROR) && q_rot_zero) |-> (res_o == q_plain));

    // R1
    zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_mode != SH_ROL && q_mode != SH_ROR && q_amt == '0) |-> (res_o == q_plain && !sat_o));

endmodule

bind bidir_sat_shifter bidir_sat_shifter_chk #(
    .DATA_W  (DATA_W),
    .REG_OUT (REG_OUT)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .amt_i  (amt_i),
    .mode_i (mode_i),
    .wide_i (wide_i),
    .res_o  (res_o),
    .sat_o  (sat_o)
);

// File: tb/bidir_sat_shifter_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies a vector at the falling edge and
// queues the expected result; the monitor pops one item after each rising
// edge (registered output) and compares.
module bidir_sat_shifter_tb_top;

    typedef struct {
        logic [63:0] res;
        logic        sat;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic [6:0]  amt_i = '0;
    logic [2:0]  mode_i = '0;
    logic        wide_i = 1'b0;
    logic [63:0] res_o;
    logic        sat_o;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    bidir_sat_shifter dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .amt_i  (amt_i),
        .mode_i (mode_i),
        .wide_i (wide_i),
        .res_o  (res_o),
        .sat_o  (sat_o)
    );

    // Reference built from the written requirements; returns {sat, result}
    function automatic logic [64:0] model(input logic [2:0] md, input logic wd,
                                          input logic signed [6:0] am, input logic [63:0] s);
        logic              narrow, arith, neg, leftd, use_sat, sat, fits;
        int                m, w, r;
        logic [63:0]       x, y, res;
        logic signed [63:0] xs, ys;
        logic [31:0]       lo, r32, sv32, o;
        narrow = !wd || md == 3'd4 || md == 3'd5;
        arith  = !(md == 3'd1 || md == 3'd3);
        x      = narrow ? (arith ? {{32{s[31]}}, s[31:0]} : {32'b0, s[31:0]}) : s;
        neg    = am < 0;
        m      = neg ? -int'(am) : int'(am);
        sat    = 1'b0;
        lo     = s[31:0];
        o      = s[31:0];
        if (md >= 3'd6) begin
            w = narrow ? 32 : 64;
            r = ((int'(am) % w) + w) % w;
            if (md == 3'd7) r = (w - r) % w;
            if (narrow) begin
                r32 = (r == 0) ? lo : ((lo << r) | (lo >> (32 - r)));
                res = {32'b0, r32};
            end else begin
                res = (r == 0) ? s : ((s << r) | (s >> (64 - r)));
            end
        end else begin
            leftd = (md == 3'd2 || md == 3'd3 || md == 3'd4) ^ neg;
            if (leftd) begin
                y = neg ? ((x << (m - 1)) << 1) : (x << m);
            end else if (arith) begin
                xs = x;
                ys = neg ? ((xs >>> (m - 1)) >>> 1) : (xs >>> m);
                y  = ys;
            end else begin
                y = neg ? ((x >> (m - 1)) >> 1) : (x >> m);
            end
            use_sat = (md == 3'd4 && !neg) || (md == 3'd5 && neg);
            if (use_sat) begin
                ys   = y;
                fits = (ys >= -64'sd2147483648) && (ys <= 64'sd2147483647);
                sv32 = fits ? y[31:0] : (ys < 0 ? 32'h8000_0000 : 32'h7FFF_FFFF);
                if (sv32[31] != o[31]) begin
                    r32 = o[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
                    sat = 1'b1;
                end else if (!o[31] && o != 0 && y == 0) begin
                    r32 = 32'h7FFF_FFFF;
                    sat = 1'b1;
                end else begin
                    r32 = sv32;
                    sat = !fits;
                end
                res = {32'b0, r32};
            end else begin
                res = y;
            end
            if (narrow) res[63:32] = '0;
        end
        return {sat, res};
    endfunction

    // Driver: apply one vector at the falling edge and queue its expectation
    task automatic drive(input logic [2:0] md, input logic wd, input int am,
                         input logic [63:0] s, input string tag);
        exp_t        e;
        logic [64:0] mv;
        @(negedge clk);
        mode_i = md;
        wide_i = wd;
        amt_i  = am[6:0];
        src_i  = s;
        mv     = model(md, wd, am[6:0], s);
        e.res  = mv[63:0];
        e.sat  = mv[64];
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: one result per rising edge, sampled just after it
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (res_o !== e.res || sat_o !== e.sat) begin
                errors++;
                $display("FAIL %s: res=%h sat=%b expected res=%h sat=%b",
                         e.tag, res_o, sat_o, e.res, e.sat);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: res=%h sat=%b expected completion", res_o, sat_o);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset clears the output register even with busy inputs
        src_i  = 64'hFFFF_FFFF_FFFF_FFFF;
        mode_i = 3'd4;
        amt_i  = 7'd5;
        wide_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (res_o !== 64'd0 || sat_o !== 1'b0) begin
            errors++;
            $display("FAIL R11: res=%h sat=%b expected res=0 sat=0", res_o, sat_o);
        end
        rst_n = 1'b1;

        // R1: natural directions, 64-bit
        drive(3'd0, 1'b1, 4,  64'hF000_0000_0000_0010, "R1");
        drive(3'd1, 1'b1, 4,  64'hF000_0000_0000_0010, "R1");
        drive(3'd2, 1'b1, 8,  64'h00FF_0000_0000_00AB, "R1");
        drive(3'd3, 1'b1, 63, 64'h0000_0000_0000_0003, "R1");
        drive(3'd0, 1'b1, 0,  64'h8123_4567_89AB_CDEF, "R1");
        // R2: reversed directions
        drive(3'd0, 1'b1, -1, 64'h0000_0000_0000_0001, "R2");
        drive(3'd2, 1'b1, -4, 64'h8000_0000_0000_0000, "R2");
        drive(3'd3, 1'b1, -4, 64'h8000_0000_0000_0000, "R2");
        drive(3'd1, 1'b1, -12, 64'h0123_4567_89AB_CDEF, "R2");
        // R4: full-width magnitudes
        drive(3'd2, 1'b1, -64, 64'h8000_0000_0000_0000, "R4");
        drive(3'd3, 1'b1, -64, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        drive(3'd0, 1'b1, -64, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        drive(3'd2, 1'b0, 40, 64'h0000_0000_FFFF_FFFF, "R4");
        drive(3'd0, 1'b0, 40, 64'h0000_0000_8000_0000, "R4");
        // R3: narrow width
        drive(3'd1, 1'b0, 4,  64'hDEAD_BEEF_8000_0000, "R3");
        drive(3'd0, 1'b0, 4,  64'hDEAD_BEEF_8000_0000, "R3");
        drive(3'd2, 1'b0, -4, 64'h1234_5678_F000_0000, "R3");
        // R5 / R6 / R7: saturating left
        drive(3'd4, 1'b1, 1,  64'hFFFF_0000_4000_0000, "R5");
        drive(3'd4, 1'b0, 2,  64'h0000_0000_C000_0000, "R5");
        drive(3'd4, 1'b0, 63, 64'h0000_0000_0000_0001, "R5");
        drive(3'd4, 1'b0, 1,  64'h0000_0000_C000_0000, "R7");
        drive(3'd4, 1'b0, -4, 64'h0000_0000_8765_4321, "R7");
        drive(3'd4, 1'b1, 3,  64'hAAAA_AAAA_0000_0005, "R7");
        // R8 / R6: saturating right
        drive(3'd5, 1'b0, -64, 64'h0000_0000_0000_0001, "R6");
        drive(3'd5, 1'b0, -64, 64'h0000_0000_FFFF_FFFF, "R8");
        drive(3'd5, 1'b0, -5, 64'h0000_0000_0000_0000, "R8");
        drive(3'd5, 1'b1, 4,  64'h5555_5555_8000_0000, "R8");
        drive(3'd5, 1'b0, -2, 64'h0000_0000_2000_0000, "R8");
        // R9: rotates
        drive(3'd6, 1'b1, 0,  64'h0123_4567_89AB_CDEF, "R9");
        drive(3'd6, 1'b1, 4,  64'h0123_4567_89AB_CDEF, "R9");
        drive(3'd6, 1'b1, -4, 64'h0123_4567_89AB_CDEF, "R9");
        drive(3'd7, 1'b0, 8,  64'hFFFF_FFFF_1234_5678, "R9");
        drive(3'd7, 1'b0, 32, 64'hFFFF_FFFF_1234_5678, "R9");
        drive(3'd6, 1'b0, -1, 64'h0000_0000_8000_0001, "R9");
        // R10: mixed sweep of every mode, width and amount
        for (int i = 0; i < 400; i++) begin
            drive(3'($urandom), 1'($urandom), int'($signed(7'($urandom))),
                  {$urandom, $urandom} >> ($urandom % 40), "R10");
        end
        repeat (3) @(posedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule